// File: doc/BRIEF.md
# Dual-CPU priority interrupt controller

This block gathers interrupt requests for a pair of processors, a master and a slave, and presents each of them with a single priority line plus the vector it should take when it accepts that line. Five request kinds feed it. Four of them are pulses: a reset request, a vertical-blank event, a horizontal-line event and a sound-timer event. The fifth, a command (mailbox) interrupt, is a level that tracks a per-processor flag. Each processor has its own mask and its own set of pending bits.

Pulsed requests are latched into the pending bits, and stay there until the processor acknowledges them. The command bit is recomputed every clock. The highest pending position is turned into a registered priority line, which is held at zero unless the adapter is both enabled and out of reset. An acknowledge clears the bit that the line currently names and returns a vector derived from that line.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A pulse on `src_reset` sets pending position 7 of both processors on that clock edge, whatever their masks hold.
- R2: The vblank, hline and sound pulses set pending positions 6, 5 and 3 only when mask bits 3, 2 and 0 of that processor are set. Mask bit n gates pending position n+3.
- R3: Pending position 4 (command) is set on the edge after mask bit 1 and the processor's command flag are both high, and it is cleared on the edge after either one goes low. `cmd_flag[0]` belongs to the master and `cmd_flag[1]` to the slave.
- R4: The line output is twice the index of the highest set pending position, or 0 if no position is set. It is registered, so it follows the pending state one clock later.
- R5: The vector output always equals 64 plus half of the line output.
- R6: Both line outputs are 0 unless `ctl_enable` and `ctl_release` are both high.
- R7: An acknowledge clears the pending position named by the current line. It has no effect when the line is 0, and it never clears the command position. A pulse that arrives in the same clock as its own acknowledge leaves the bit set.
- R8: Clearing a mask bit does not drop a request that is already pending.
- R9: A synchronous reset clears all pending state. Afterwards both lines read 0 and both vectors read 64.
- R10: Masks, flags and acknowledges of one processor do not change the other processor's pending state or outputs, except through `src_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Adapter enable bit |
| ctl_release | input | 1 | Adapter reset-release bit |
| src_reset | input | 1 | Reset-request pulse for both processors |
| src_vblank | input | 1 | Vertical-blank pulse |
| src_hline | input | 1 | Horizontal-line pulse |
| src_sound | input | 1 | Sound-timer pulse |
| mask_m | input | 4 | Master mask: bit0 sound, bit1 command, bit2 hline, bit3 vblank |
| mask_s | input | 4 | Slave mask, same layout as the master mask |
| cmd_flag | input | 2 | Command flags: bit0 master, bit1 slave |
| ack | input | 2 | Acknowledge strobes: bit0 master, bit1 slave |
| line_m | output | 4 | Master priority line (0..14, always even) |
| line_s | output | 4 | Slave priority line |
| vec_m | output | 8 | Master acknowledge vector |
| vec_s | output | 8 | Slave acknowledge vector |

## Verification
Wrong pending state in this block shows up on the line outputs one clock after the edge that corrupted it. An incorrect vector shows up at once, because the vector is a function of the registered line. An acknowledge that clears the wrong bit, or fails to clear one, leaves a stale or lowered line on the very next clock. A lost pulse or a mask applied to the wrong position becomes visible as soon as that source should rank highest. For these reasons the bench compares both lines and both vectors against a behavioural model on every clock, during directed corner cases and during a pseudo-random stretch.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PEND_W     = 8;
    localparam int IDX_W      = $clog2(PEND_W);
    localparam int MASK_W     = 4;
    localparam int MASK_SHIFT = 3;
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 64;
    localparam int NCPU       = 2;

    // pending positions; order is priority
    localparam int POS_RESET  = 7;
    localparam int POS_VBLANK = 6;
    localparam int POS_HLINE  = 5;
    localparam int POS_CMD    = 4;
    localparam int POS_SOUND  = 3;

    typedef struct packed {
        logic reset_req;
        logic vblank;
        logic hline;
        logic sound;
    } irq_src_t;

    function automatic logic [PEND_W-1:0] src_to_vec(input irq_src_t s);
        logic [PEND_W-1:0] v;
        v = '0;
        v[POS_RESET]  = s.reset_req;
        v[POS_VBLANK] = s.vblank;
        v[POS_HLINE]  = s.hline;
        v[POS_SOUND]  = s.sound;
        return v;
    endfunction

    function automatic logic [IDX_W-1:0] top_index(input logic [PEND_W-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < PEND_W; i++)
            if (v[i]) idx = IDX_W'(i);
        return idx;
    endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_src_t          src,
    input  logic [MASK_W-1:0] mask,
    input  logic              cmd_flag,
    input  logic              ack,
    input  logic [IDX_W-1:0]  cur_idx,
    output logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] CMD_BIT   = PEND_W'(1) << POS_CMD;
    localparam logic [PEND_W-1:0] RESET_BIT = PEND_W'(1) << POS_RESET;
    localparam logic [PEND_W-1:0] LIVE_BITS = ~((PEND_W'(1) << MASK_SHIFT) - PEND_W'(1));

    logic [PEND_W-1:0] gate, set_v, clr_v, nxt;
    logic              cmd_level;

    always_comb begin
        gate      = RESET_BIT | (PEND_W'(mask) << MASK_SHIFT);
        set_v     = src_to_vec(src) & gate & ~CMD_BIT;
        clr_v     = '0;
        if (ack && cur_idx != '0 && cur_idx != IDX_W'(POS_CMD))
            clr_v = PEND_W'(1) << cur_idx;
        cmd_level = mask[1] & cmd_flag;
        nxt       = ((pend & ~clr_v) | set_v) & LIVE_BITS & ~CMD_BIT;
        if (cmd_level) nxt = nxt | CMD_BIT;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= nxt;
    end

    // R1
    reset_req_sets_chk: assert property (@(posedge clk) disable iff (rst)
        src.reset_req |=> pend[POS_RESET]);
    // R2
    masked_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend[POS_VBLANK] && src.vblank && !mask[3]) |=> !pend[POS_VBLANK]);
    // R3
    cmd_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mask[1] && cmd_flag) |=> pend[POS_CMD]);
    // R3
    cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(mask[1] && cmd_flag) |=> !pend[POS_CMD]);
    // R7
    ack_clears_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && cur_idx == IDX_W'(POS_VBLANK) && !src.vblank) |=> !pend[POS_VBLANK]);
    // R8
    hold_hline_chk: assert property (@(posedge clk) disable iff (rst)
        (pend[POS_HLINE] && !(ack && cur_idx == IDX_W'(POS_HLINE))) |=> pend[POS_HLINE]);
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [PEND_W-1:0] pend,
    output logic [IDX_W-1:0]  idx_q,
    output logic [IDX_W:0]    line,
    output logic [VEC_W-1:0]  vec
);
    always_ff @(posedge clk) begin
        if (rst)          idx_q <= '0;
        else if (!enable) idx_q <= '0;
        else              idx_q <= top_index(pend);
    end

    always_comb begin
        line = {idx_q, 1'b0};
        vec  = VEC_W'(VEC_BASE) + VEC_W'(line >> 1);
    end

    // R6
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> idx_q == '0);
    // R4
    reset_top_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && pend[POS_RESET]) |=> idx_q == IDX_W'(POS_RESET));
    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> idx_q == '0);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              ctl_release,
    input  logic              src_reset,
    input  logic              src_vblank,
    input  logic              src_hline,
    input  logic              src_sound,
    input  logic [MASK_W-1:0] mask_m,
    input  logic [MASK_W-1:0] mask_s,
    input  logic [NCPU-1:0]   cmd_flag,
    input  logic [NCPU-1:0]   ack,
    output logic [IDX_W:0]    line_m,
    output logic [IDX_W:0]    line_s,
    output logic [VEC_W-1:0]  vec_m,
    output logic [VEC_W-1:0]  vec_s
);
    irq_src_t                      src;
    logic                          live;
    logic [NCPU-1:0][MASK_W-1:0]   mask_a;
    logic [NCPU-1:0][PEND_W-1:0]   pend_a;
    logic [NCPU-1:0][IDX_W-1:0]    idx_a;
    logic [NCPU-1:0][IDX_W:0]      line_a;
    logic [NCPU-1:0][VEC_W-1:0]    vec_a;

    assign src    = '{reset_req: src_reset, vblank: src_vblank,
                      hline: src_hline, sound: src_sound};
    assign live   = ctl_enable & ctl_release;
    assign mask_a = {mask_s, mask_m};

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_pending u_pend (
            .clk(clk), .rst(rst), .src(src), .mask(mask_a[c]),
            .cmd_flag(cmd_flag[c]), .ack(ack[c]), .cur_idx(idx_a[c]),
            .pend(pend_a[c])
        );
        irq_level_enc u_enc (
            .clk(clk), .rst(rst), .enable(live), .pend(pend_a[c]),
            .idx_q(idx_a[c]), .line(line_a[c]), .vec(vec_a[c])
        );
    end

    assign line_m = line_a[0];
    assign line_s = line_a[1];
    assign vec_m  = vec_a[0];
    assign vec_s  = vec_a[1];

    // R5
    vec_match_chk: assert property (@(posedge clk) disable iff (rst)
        vec_m == VEC_W'(VEC_BASE) + VEC_W'(line_m >> 1));
    // R9
    after_reset_chk: assert property (@(posedge clk)
        rst |=> (line_m == '0 && line_s == '0));
    // R10
    slave_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_a[1] == '0 && !src_reset && !src_vblank && !src_hline && !src_sound
         && !cmd_flag[1]) |=> pend_a[1] == '0);
endmodule

// File: tb/sim_dual_irq_ctrl.sv
module sim_dual_irq_ctrl;
    logic clk = 0, rst = 1;
    logic ctl_enable = 0, ctl_release = 0;
    logic src_reset = 0, src_vblank = 0, src_hline = 0, src_sound = 0;
    logic [3:0] mask_m = 0, mask_s = 0;
    logic [1:0] cmd_flag = 0, ack = 0;
    logic [3:0] line_m, line_s;
    logic [7:0] vec_m, vec_s;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R9";
    int pend [2][8];
    int lvl [2];

    always #4 clk = ~clk;

    dual_irq_ctrl u0 (.*);

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        int nl [2];
        int np [2][8];
        int m;
        for (int c = 0; c < 2; c++) begin
            m = (c == 0) ? int'(mask_m) : int'(mask_s);
            nl[c] = 0;
            if (ctl_enable && ctl_release)
                for (int b = 0; b < 8; b++) if (pend[c][b] != 0) nl[c] = b;
            for (int b = 0; b < 8; b++) np[c][b] = pend[c][b];
            if (ack[c] && lvl[c] != 0 && lvl[c] != 4) np[c][lvl[c]] = 0;
            if (src_reset) np[c][7] = 1;
            if (src_vblank && m[3]) np[c][6] = 1;
            if (src_hline && m[2]) np[c][5] = 1;
            if (src_sound && m[0]) np[c][3] = 1;
            np[c][4] = (m[1] && cmd_flag[c]) ? 1 : 0;
        end
        for (int c = 0; c < 2; c++) begin
            lvl[c] = rst ? 0 : nl[c];
            for (int b = 0; b < 8; b++) pend[c][b] = rst ? 0 : np[c][b];
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        cycles++;
        chk("line_m", int'(line_m), 2 * lvl[0]);
        chk("line_s", int'(line_s), 2 * lvl[1]);
        chk("vec_m (R5)", int'(vec_m), 64 + lvl[0]);
        chk("vec_s (R5)", int'(vec_s), 64 + lvl[1]);
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulses();
        src_reset = 0; src_vblank = 0; src_hline = 0; src_sound = 0; ack = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int c = 0; c < 2; c++) begin
            lvl[c] = 0;
            for (int b = 0; b < 8; b++) pend[c][b] = 0;
        end
        // R9 reset state
        step(3);
        chk("R9 reset line_m", int'(line_m), 0);
        chk("R9 reset vec_s", int'(vec_s), 64);
        rst = 0; ctl_enable = 1; ctl_release = 1;
        step(2);

        // R1 reset request ignores masks
        tag = "R1";
        src_reset = 1; step(1); clear_pulses(); step(2);
        chk("R1 line_m", int'(line_m), 14);
        chk("R1 line_s", int'(line_s), 14);
        ack = 2'b11; step(1); clear_pulses(); step(2);
        chk("R7 ack cleared", int'(line_m), 0);

        // R2 masked vs unmasked vblank
        tag = "R2";
        src_vblank = 1; step(1); clear_pulses(); step(2);
        chk("R2 masked vblank", int'(line_m), 0);
        mask_m = 4'b1000;
        src_vblank = 1; step(1); clear_pulses(); step(2);
        chk("R2 vblank master", int'(line_m), 12);
        chk("R10 slave untouched", int'(line_s), 0);

        // R8 removing the mask keeps the request
        tag = "R8";
        mask_m = 0; step(3);
        chk("R8 still pending", int'(line_m), 12);
        ack = 2'b01; step(1); clear_pulses(); step(2);

        // R3 command level
        tag = "R3";
        mask_m = 4'b0010; cmd_flag = 2'b01; step(3);
        chk("R3 cmd set", int'(line_m), 8);
        ack = 2'b01; step(1); clear_pulses(); step(2);
        chk("R7 ack keeps cmd", int'(line_m), 8);
        cmd_flag = 0; step(3);
        chk("R3 cmd cleared", int'(line_m), 0);

        // R4 priority among several
        tag = "R4";
        mask_m = 4'b0101; src_sound = 1; src_hline = 1; step(1); clear_pulses(); step(2);
        chk("R4 hline over sound", int'(line_m), 10);
        ack = 2'b01; step(1); clear_pulses(); step(2);
        chk("R4 sound next", int'(line_m), 6);

        // R6 gating
        tag = "R6";
        ctl_enable = 0; step(2);
        chk("R6 enable low", int'(line_m), 0);
        ctl_enable = 1; ctl_release = 0; step(2);
        chk("R6 release low", int'(line_m), 0);
        ack = 2'b01; step(1); clear_pulses();
        ctl_release = 1; step(2);
        chk("R7 ack at line 0 ignored", int'(line_m), 6);

        // R7 pulse together with its own acknowledge
        tag = "R7";
        src_hline = 1; step(1); clear_pulses(); step(2);
        chk("R7 hline up", int'(line_m), 10);
        src_hline = 1; ack = 2'b01; step(1); clear_pulses(); step(2);
        chk("R7 re-pulse kept", int'(line_m), 10);

        // R10 slave command only
        tag = "R10";
        mask_s = 4'b0010; cmd_flag = 2'b10; step(3);
        chk("R10 slave cmd", int'(line_s), 8);
        chk("R10 master unchanged", int'(line_m), 10);
        cmd_flag = 0; mask_s = 0; step(2);

        // R4 pseudo-random stretch
        tag = "R4";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            src_reset  = (lfsr[3:0] == 4'hF);
            src_vblank = lfsr[4] & lfsr[5];
            src_hline  = lfsr[6] & lfsr[7];
            src_sound  = lfsr[8];
            mask_m     = lfsr[12:9];
            mask_s     = lfsr[15:12];
            cmd_flag   = lfsr[1:0];
            ack        = lfsr[11:10];
            ctl_enable = (lfsr[7:5] != 3'b000);
            step(1);
        end
        clear_pulses();
        step(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule